// File: doc/BRIEF.md
# Fault-Tolerant Tick Generator Node

This block is one member of a fully connected cluster of `N` nodes that together produce a common, approximately synchronized tick stream. The cluster keeps running even when up to `F` of its members misbehave. A tick travels on a single wire as a bare level change. The first change after reset is a rise, the next a fall, and so on. The node listens to the `N-1` peer wires and drives its own tick wire, which all peers see.

Each peer wire is synchronized and edge-detected. For every peer, the node keeps a small saturating signed difference: ticks received from that peer minus ticks the node has emitted. Two flags come from each difference, "peer ahead" (difference above zero) and "peer level or ahead" (difference zero or more). Threshold units count these flags. The catch-up rule advances the node when enough peers are ahead. The pacing rule advances it when enough peers have reached its current count. Rising and falling ticks use separate threshold units, selected by the current output level.

The parameter `BYZ` selects the thresholds. With `BYZ=1` the node tolerates arbitrary faults and needs `N >= 3F+2`. With `BYZ=0` it tolerates only omission faults.

Top module: `tick_node`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `tick_out` becomes 0 and every peer difference becomes 0. The reset level stands for tick 0, which is therefore announced once without a transition.
- R2: A level change on `tick_in[i]` counts as exactly one tick from peer i. The earliest `tick_out` can respond to it is at the fourth rising edge after the change: two synchronizer stages, one difference update, then the output register.
- R3: With `BYZ=1`, the catch-up threshold is F+1 peers and the pacing threshold is 2F+1 peers. With `BYZ=0`, they are 1 peer and F+1 peers.
- R4: If at a clock edge the number of peers with a difference above zero is at least the catch-up threshold, `tick_out` inverts at that edge.
- R5: If at a clock edge the number of peers with a difference of zero or more is at least the pacing threshold, `tick_out` inverts at that edge.
- R6: If neither threshold is met, `tick_out` holds its value.
- R7: `tick_out` changes at most once per clock. A catch-up over several ticks is spread over successive cycles, and each emitted tick lowers every difference by one.
- R8: Each difference saturates within -LIM..+LIM (default 4). If a received tick and an emitted tick fall in the same cycle, the difference is unchanged.
- R9: With `BYZ=1` and F≥1, once a node has emitted its first tick, a single peer that stays stuck or toggles at will cannot make it advance while all other peers are silent.
- R10: Ticks alternate. A tick emitted while `tick_out` is 0 is a rise, and one emitted while it is 1 is a fall. Both directions obey R4 to R6 identically.
- R11: In a cluster of N=5, F=1 with one stuck or babbling member, the emitted tick counts of any two correct nodes never differ by more than one, and every correct node keeps advancing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_in | input | N-1 | Peer tick wires, one level change per tick, asynchronous to clk |
| tick_out | output | 1 | Own tick wire, one level change per emitted tick |

## Verification
The bench targets the point where a lone peer is far ahead. A node that counted "ahead" flags against the wrong threshold, or treated "ahead" and "level" alike, would be dragged forward by a single babbling wire. It checks the exact four-edge latency, because a missing or extra synchronizer stage shifts every later tick by a cycle. It drives bursts of peer edges so that differences hit the ±4 bound: a design that wraps instead of saturating would suddenly see a far-ahead peer as far behind and stall. A model of both threshold modes, followed every cycle under random peer activity, exposes swapped rise/fall units, an emission of more than one tick per cycle, or a lost simultaneous receive-and-emit. A small cluster with a stuck and then a babbling member shows whether the correct nodes stay within one tick of each other and keep moving.

// File: rtl/tick_node_pkg.sv
// Shared helpers for the tick generator node: rule thresholds per fault
// mode and the width of the saturating peer difference.
package tick_node_pkg;

    // Peers that must be ahead before the node catches up.
    function automatic int relay_need(bit byz, int f);
        return byz ? f + 1 : 1;
    endfunction

    // Peers that must have reached the local count before the node paces on.
    function automatic int incr_need(bit byz, int f);
        return byz ? 2 * f + 1 : f + 1;
    endfunction

    // Signed width holding -lim..+lim.
    function automatic int diff_width(int lim);
        return $clog2(lim + 1) + 1;
    endfunction

endpackage

// File: rtl/tick_sync_edge.sv
// Two-flop synchronizer plus one history flop for one peer tick wire.
// Assumes the peer wire holds each level for at least two clocks, so no
// tick is lost. hit is high for one cycle per level change seen.
module tick_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic hit
);
    logic meta_q, sync_q, hist_q;

    // Shift the peer level through the synchronizer and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            hist_q <= sync_q;
        end
    end

    assign hit = sync_q ^ hist_q;
endmodule

// File: rtl/tick_diff_chan.sv
// Saturating signed difference for one peer: ticks received minus ticks
// emitted, bounded to -LIM..+LIM. Provides the "peer ahead" and
// "peer level or ahead" flags for the threshold units.
module tick_diff_chan #(
    parameter int LIM = 4,
    parameter int DW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up,
    input  logic          down,
    output logic [DW-1:0] diff,
    output logic          ahead,
    output logic          level
);
    localparam logic signed [DW:0] HI = (DW+1)'(LIM);
    localparam logic signed [DW:0] LO = -HI;

    logic signed [DW:0]   sum;
    logic        [DW-1:0] nxt;

    // Form the unclamped next difference and clamp it to the bound.
    always_comb begin
        sum = $signed({diff[DW-1], diff})
            + $signed({{DW{1'b0}}, up})
            - $signed({{DW{1'b0}}, down});
        if (sum > HI)
            nxt = HI[DW-1:0];
        else if (sum < LO)
            nxt = LO[DW-1:0];
        else
            nxt = sum[DW-1:0];
    end

    // Hold the difference.
    always_ff @(posedge clk) begin
        if (!rst_n)
            diff <= '0;
        else
            diff <= nxt;
    end

    assign level = !diff[DW-1];
    assign ahead = level && (diff != '0);
endmodule

// File: rtl/tick_threshold.sv
// m-out-of-W vote: fires when enabled and at least NEED flags are set.
module tick_threshold #(
    parameter int W    = 4,
    parameter int NEED = 2
) (
    input  logic         en,
    input  logic [W-1:0] flags,
    output logic         fire
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] tally;

    // Count the set flags.
    always_comb begin
        tally = '0;
        for (int i = 0; i < W; i++)
            tally = tally + CW'(flags[i]);
    end

    assign fire = en && (int'(tally) >= NEED);
endmodule

// File: rtl/tick_node.sv
// One node of a fault-tolerant tick cluster. Assumes N >= 3F+2 when BYZ=1
// and peer wires that hold each level for at least two clocks. Emits at
// most one tick per clock; rising and falling ticks use separate units.
module tick_node
    import tick_node_pkg::*;
#(
    parameter int N   = 5,
    parameter int F   = 1,
    parameter bit BYZ = 1'b1,
    parameter int LIM = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-2:0] tick_in,
    output logic         tick_out
);
    localparam int R          = N - 1;
    localparam int RELAY_NEED = relay_need(BYZ, F);
    localparam int INCR_NEED  = incr_need(BYZ, F);
    localparam int DW         = diff_width(LIM);

    logic [R-1:0]         hit, ahead, level;
    logic [R-1:0][DW-1:0] diff_q;
    logic [1:0]           relay_fire, incr_fire;
    logic                 advance;

    // Per-peer synchronizer and difference tracker.
    for (genvar ch = 0; ch < R; ch++) begin : g_peer
        tick_sync_edge u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (tick_in[ch]),
            .hit   (hit[ch])
        );
        tick_diff_chan #(.LIM(LIM), .DW(DW)) u_diff (
            .clk   (clk),
            .rst_n (rst_n),
            .up    (hit[ch]),
            .down  (advance),
            .diff  (diff_q[ch]),
            .ahead (ahead[ch]),
            .level (level[ch])
        );
    end

    // Unit pair 0 decides rising ticks, pair 1 falling ticks.
    for (genvar p = 0; p < 2; p++) begin : g_dir
        tick_threshold #(.W(R), .NEED(RELAY_NEED)) u_relay (
            .en    (tick_out == 1'(p)),
            .flags (ahead),
            .fire  (relay_fire[p])
        );
        tick_threshold #(.W(R), .NEED(INCR_NEED)) u_incr (
            .en    (tick_out == 1'(p)),
            .flags (level),
            .fire  (incr_fire[p])
        );
    end

    assign advance = (|relay_fire) || (|incr_fire);

    // Emit one tick transition when either rule fires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_out <= 1'b0;
        else if (advance)
            tick_out <= ~tick_out;
    end
endmodule

// File: rtl/tick_node_chk.sv
// Assertion checker for tick_node, attached by bind below.
module tick_node_chk #(
    parameter int R          = 4,
    parameter int DW         = 4,
    parameter int LIM        = 4,
    parameter int RELAY_NEED = 2,
    parameter int INCR_NEED  = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick_out,
    input logic [R-1:0]         ahead,
    input logic [R-1:0]         level,
    input logic [R-1:0][DW-1:0] diff_q
);
    // R1: reset clears output and differences.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (tick_out == 1'b0 && diff_q == '0));

    // R4: enough peers ahead forces a tick.
    a_r4_relay_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ahead) >= RELAY_NEED) |=> (tick_out != $past(tick_out)));

    // R5: enough peers level forces a tick.
    a_r5_incr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(level) >= INCR_NEED) |=> (tick_out != $past(tick_out)));

    // R6: no rule met, no tick.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ahead) < RELAY_NEED && $countones(level) < INCR_NEED)
        |=> $stable(tick_out));

    // R8: every difference stays in bound.
    for (genvar ch = 0; ch < R; ch++) begin : g_bound
        a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(diff_q[ch]) <= LIM && $signed(diff_q[ch]) >= -LIM));
    end
endmodule

bind tick_node tick_node_chk #(
    .R(R), .DW(DW), .LIM(LIM), .RELAY_NEED(RELAY_NEED), .INCR_NEED(INCR_NEED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_out(tick_out),
    .ahead(ahead), .level(level), .diff_q(diff_q)
);

// File: tb/tick_node_test.sv
// Bench: two stand-alone nodes (both fault modes) against a behavioural
// model every clock, plus a five-node cluster with one faulty member.
module tick_node_test;
    localparam int N = 5;
    localparam int F = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rem = '0;
    logic       t_byz, t_om;
    logic       fz = 1'b0;
    logic [3:0] c;

    always #10 clk = ~clk;

    tick_node #(.N(N), .F(F), .BYZ(1'b1), .LIM(4)) uut (
        .clk(clk), .rst_n(rst_n), .tick_in(rem), .tick_out(t_byz));
    tick_node #(.N(N), .F(F), .BYZ(1'b0), .LIM(4)) uut_om (
        .clk(clk), .rst_n(rst_n), .tick_in(rem), .tick_out(t_om));

    tick_node #(.N(N), .F(F), .BYZ(1'b1)) cl0 (
        .clk(clk), .rst_n(rst_n), .tick_in({fz, c[3], c[2], c[1]}), .tick_out(c[0]));
    tick_node #(.N(N), .F(F), .BYZ(1'b1)) cl1 (
        .clk(clk), .rst_n(rst_n), .tick_in({fz, c[3], c[2], c[0]}), .tick_out(c[1]));
    tick_node #(.N(N), .F(F), .BYZ(1'b1)) cl2 (
        .clk(clk), .rst_n(rst_n), .tick_in({fz, c[3], c[1], c[0]}), .tick_out(c[2]));
    tick_node #(.N(N), .F(F), .BYZ(1'b1)) cl3 (
        .clk(clk), .rst_n(rst_n), .tick_in({fz, c[2], c[1], c[0]}), .tick_out(c[3]));

    int    errors = 0;
    int    checks = 0;
    string tag = "R1";
    int    om_moves = 0;
    bit    prev_om = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural model: peer histories, integer differences, thresholds.
    bit h1[4], h2[4], h3[4];
    int md[2][4];
    bit et[2];
    int rth[2] = '{2, 1};   // R3 catch-up need: byz F+1, omission 1
    int ith[2] = '{3, 2};   // R3 pacing need: byz 2F+1, omission F+1

    always @(posedge clk) begin
        int g, q, nd;
        bit adv;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                h1[i] = 0; h2[i] = 0; h3[i] = 0;
                md[0][i] = 0; md[1][i] = 0;
            end
            et[0] = 0; et[1] = 0;
        end else begin
            for (int m = 0; m < 2; m++) begin
                g = 0; q = 0;
                for (int i = 0; i < 4; i++) begin
                    if (md[m][i] > 0) g++;
                    if (md[m][i] >= 0) q++;
                end
                adv = (g >= rth[m]) || (q >= ith[m]);
                for (int i = 0; i < 4; i++) begin
                    nd = md[m][i] + int'(h2[i] ^ h3[i]) - int'(adv);
                    if (nd > 4) nd = 4;
                    if (nd < -4) nd = -4;
                    md[m][i] = nd;
                end
                if (adv) et[m] = ~et[m];
            end
            for (int i = 0; i < 4; i++) begin
                h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = rem[i];
            end
        end
    end

    // Compare both nodes to the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(t_byz == et[0], tag, "byz node vs model", int'(t_byz), int'(et[0]));
            check(t_om == et[1], tag, "omission node vs model", int'(t_om), int'(et[1]));
            if (t_om != prev_om) om_moves++;
            prev_om = t_om;
        end
    end

    // R11: cluster precision, tracked from observed transitions.
    int cc[4];
    bit cp[4];
    always @(negedge clk) begin
        int lo, hi;
        if (!rst_n) begin
            for (int j = 0; j < 4; j++) begin cc[j] = 0; cp[j] = 0; end
        end else begin
            for (int j = 0; j < 4; j++) begin
                if (c[j] != cp[j]) cc[j]++;
                cp[j] = c[j];
            end
            lo = cc[0]; hi = cc[0];
            for (int j = 1; j < 4; j++) begin
                if (cc[j] < lo) lo = cc[j];
                if (cc[j] > hi) hi = cc[j];
            end
            check(hi - lo <= 1, "R11", "cluster spread", hi - lo, 1);
        end
    end

    // Faulty cluster member: stuck low, then babbling.
    initial begin
        repeat (300) @(negedge clk);
        forever begin
            @(negedge clk); #1;
            if ($urandom % 3 == 0) fz = ~fz;
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        step(5);
        check(t_byz == 1'b0, "R1", "byz tick in reset", int'(t_byz), 0);
        check(t_om == 1'b0, "R1", "omission tick in reset", int'(t_om), 0);
        rst_n = 1'b1;

        // R5/R10: first rising tick from all peers level, then R6 hold
        tag = "R5";
        step(10);
        check(t_byz == 1'b1, "R5", "first rising tick", int'(t_byz), 1);
        tag = "R6";
        step(30);
        check(t_byz == 1'b1, "R6", "quiet peers hold", int'(t_byz), 1);

        // R9/R3: lone babbling peer
        tag = "R9";
        om_moves = 0;
        for (int k = 0; k < 6; k++) begin
            rem[0] = ~rem[0];
            step(2);
        end
        step(10);
        check(t_byz == 1'b1, "R9", "lone babbler cannot advance", int'(t_byz), 1);
        check(om_moves > 0, "R3", "omission node follows one peer", om_moves, 1);

        // R2/R10: two more peers reach the count, falling tick at 4th edge
        tag = "R2";
        rem[1] = ~rem[1]; rem[2] = ~rem[2];
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check(t_byz == 1'b1, "R2", "no response before 4th edge", int'(t_byz), 1);
        end
        @(negedge clk);
        check(t_byz == 1'b0, "R10", "falling tick at 4th edge", int'(t_byz), 0);
        #1;
        step(10);

        // R4/R7: two peers race ahead, catch-up spread over cycles
        tag = "R4";
        for (int k = 0; k < 3; k++) begin
            rem[1] = ~rem[1]; rem[2] = ~rem[2];
            step(2);
        end
        step(15);

        // R8: burst on one peer drives its difference into saturation
        tag = "R8";
        for (int k = 0; k < 10; k++) begin
            rem[3] = ~rem[3];
            step(2);
        end
        step(20);

        // R7: random peer activity
        tag = "R7";
        for (int k = 0; k < 500; k++) begin
            if ($urandom % 4 == 0) rem = rem ^ 4'($urandom);
            step(2);
        end
        step(20);

        // R11: every correct cluster node kept advancing
        for (int j = 0; j < 4; j++)
            check(cc[j] >= 50, "R11", "cluster node progress", cc[j], 50);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule